// File: doc/BRIEF.md
# Prioritized Interrupt Request and Mask Unit

This unit keeps one latched request flag for each of seven interrupt levels and a mask register that holds a per-level enable for each level, plus a global enable. Hardware sources raise a level with a one-cycle pulse. Software reads and writes the request register like any other register. Writing a 1 into a request bit creates a software interrupt at that level, and software-made requests go through the same masking as hardware ones.

Each cycle the unit picks, from the pending requests whose enables are set, the one with the highest priority. It offers that level and a pending flag to the CPU entry sequencer. When the sequencer acknowledges the level, the matching request bit is cleared. The sequencer can also clear the global enable with a strobe. A software write to the mask register in the same cycle overrides that strobe.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the request register and the mask register both read 0, `irq_pending` is 0 and `irq_level` is 0.
- R2: A one-cycle pulse on bit i of `hw_set` sets request bit i, and the bit reads back as 1 from the next cycle on. Other bits keep their value.
- R3: A write with `req_we` loads `req_wdata` into the request register. Writing 1 to a bit makes a request that behaves the same as a hardware one.
- R4: When `req_we` and a `hw_set` bit are asserted in the same cycle, the register takes exactly `req_wdata`, and a hardware set of a bit written 0 is lost.
- R5: `mask_we` loads `mask_wdata`. Mask bits 0..6 are the level enables and bit 7 is the global enable.
- R6: `irq_pending` is 1 only when some request bit i is set, mask bit i is set and mask bit 7 is set. With the global enable at 0, nothing is pending.
- R7: Level 0 has the highest priority. `irq_level` is the lowest-numbered request that is pending and enabled.
- R8: `irq_ack` with `irq_pending` at 1 clears the request bit of the level in `irq_level` in the next cycle. In the same cycle, a hardware set of a different bit still takes effect.
- R9: `gie_clr` clears mask bit 7. When `mask_we` is asserted in the same cycle, the written value wins.
- R10: A hardware set of the same bit that is being acknowledged in that cycle leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_set | input | 7 | One-cycle hardware set pulses, one per level |
| req_we | input | 1 | Request register write strobe |
| req_wdata | input | 7 | Request register write value |
| req_rdata | output | 7 | Request register contents |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write value (bit 7 is the global enable) |
| mask_rdata | output | 8 | Mask register contents |
| gie_clr | input | 1 | Global-enable clear strobe from the entry sequencer |
| irq_ack | input | 1 | Acknowledge of the offered level |
| irq_pending | output | 1 | An enabled request is waiting |
| irq_level | output | 3 | Winning level number |

## Verification
The hardest situations to reach are the same-cycle collisions. A register write can land on a hardware pulse, a mask write can coincide with the enable-clear strobe, and a hardware set can hit the level being acknowledged. Each one needs two independent strobes aligned on a single clock edge. The directed tasks drive both strobes between the same pair of edges, then read the registers back through the ports in the next cycle. This shows which source won.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int NUM_LEVELS = 7;
    localparam int LEVEL_W    = $clog2(NUM_LEVELS);
    localparam int MASK_W     = NUM_LEVELS + 1;
    localparam int GIE_BIT    = NUM_LEVELS;

    typedef logic [NUM_LEVELS-1:0] lvl_vec_t;
    typedef logic [LEVEL_W-1:0]    lvl_num_t;

    typedef struct packed {
        lvl_vec_t            req;
        logic [MASK_W-1:0]   mask;
    } irq_state_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_ctrl_pkg::*;
(
    input  lvl_vec_t vec,
    output logic     any,
    output lvl_num_t idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = lvl_num_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  hw_set,
    input  logic        req_we,
    input  logic [6:0]  req_wdata,
    output logic [6:0]  req_rdata,
    input  logic        mask_we,
    input  logic [7:0]  mask_wdata,
    output logic [7:0]  mask_rdata,
    input  logic        gie_clr,
    input  logic        irq_ack,
    output logic        irq_pending,
    output logic [2:0]  irq_level
);
    irq_state_t st_q, st_d;
    lvl_vec_t   live_req;
    lvl_vec_t   ack_clr;
    logic       any_live;
    lvl_num_t   win_idx;

    assign live_req = st_q.req & st_q.mask[NUM_LEVELS-1:0]
                    & {NUM_LEVELS{st_q.mask[GIE_BIT]}};

    irq_prio_enc u_enc (
        .vec (live_req),
        .any (any_live),
        .idx (win_idx)
    );

    always_comb begin
        ack_clr = '0;
        if (irq_ack && any_live) ack_clr[win_idx] = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (req_we) st_d.req = req_wdata;
        else        st_d.req = (st_q.req & ~ack_clr) | hw_set;
        if (mask_we)      st_d.mask = mask_wdata;
        else if (gie_clr) st_d.mask[GIE_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_rdata   = st_q.req;
    assign mask_rdata  = st_q.mask;
    assign irq_pending = any_live;
    assign irq_level   = win_idx;

    p_pend_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (mask_rdata[7] && (req_rdata & mask_rdata[6:0]) != 0));
    p_winner_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (req_rdata[irq_level] && mask_rdata[irq_level]));
    p_sw_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_we |=> req_rdata == $past(req_wdata));
    p_hw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_we && hw_set != 0) |=> (req_rdata & $past(hw_set)) == $past(hw_set));
    p_gie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr && !mask_we) |=> !mask_rdata[7]);
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_rdata == $past(mask_wdata));
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_pending && !req_we && hw_set[irq_level] == 1'b0)
        |=> !req_rdata[$past(irq_level)]);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] hw_set = '0;
    logic       req_we = 1'b0;
    logic [6:0] req_wdata = '0;
    logic [6:0] req_rdata;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic       gie_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_pending;
    logic [2:0] irq_level;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_ctrl u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        hw_set = '0; req_we = 0; mask_we = 0; gie_clr = 0; irq_ack = 0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_we = 1; mask_wdata = v; tick();
    endtask

    task automatic wr_req(input logic [6:0] v);
        req_we = 1; req_wdata = v; tick();
    endtask

    task automatic t_reset();
        chk("R1 req", req_rdata, 0);
        chk("R1 mask", mask_rdata, 0);
        chk("R1 pending", irq_pending, 0);
        chk("R1 level", irq_level, 0);
    endtask

    task automatic t_hw_set();
        hw_set = 7'b0010000; tick();
        chk("R2 set bit4", req_rdata, 7'h10);
        hw_set = 7'b0000010; tick();
        chk("R2 other kept", req_rdata, 7'h12);
        chk("R6 no gie", irq_pending, 0);
        wr_mask(8'h7f);
        chk("R6 gie off", irq_pending, 0);
        wr_req('0);
    endtask

    task automatic t_sw_and_mask();
        wr_mask(8'h80 | 8'h20);
        chk("R5 mask rd", mask_rdata, 8'ha0);
        wr_req(7'b0100000);
        chk("R3 sw req", req_rdata, 7'h20);
        chk("R3 pending", irq_pending, 1);
        chk("R3 level", irq_level, 5);
        wr_mask(8'h80 | 8'h01);
        chk("R6 masked off", irq_pending, 0);
        wr_req('0);
    endtask

    task automatic t_priority();
        wr_mask(8'hff);
        wr_req(7'b1001100);
        chk("R7 lowest wins", irq_level, 2);
        irq_ack = 1; tick();
        chk("R8 ack clear", req_rdata, 7'h48);
        chk("R7 next", irq_level, 3);
        irq_ack = 1; hw_set = 7'b0000001; tick();
        chk("R8 ack+hw other", req_rdata, 7'h41);
        chk("R7 level0", irq_level, 0);
        irq_ack = 1; hw_set = 7'b0000001; tick();
        chk("R10 ack same bit", req_rdata, 7'h41);
        wr_req('0);
    endtask

    task automatic t_collide();
        req_we = 1; req_wdata = 7'b0000100; hw_set = 7'b0001000; tick();
        chk("R4 hw lost", req_rdata, 7'h04);
        gie_clr = 1; tick();
        chk("R9 gie clr", mask_rdata, 8'h7f);
        gie_clr = 1; mask_we = 1; mask_wdata = 8'hff; tick();
        chk("R9 write wins", mask_rdata, 8'hff);
        wr_req('0);
    endtask

    initial begin
        #1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_hw_set();
        t_sw_and_mask();
        t_priority();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule